// File: doc/BRIEF.md
# Single-precision floating-point add/subtract unit

This unit takes two 32-bit single-precision words and an operation select, and returns their sum or difference one clock later. The word layout is one sign bit at the top, an 8-bit exponent with a bias of 127 in the next bits, and a 23-bit fraction in the low bits. A normal operand carries an implied leading one. The datapath puts that bit back into the significand. It compares magnitudes, shifts the smaller significand right by the exponent gap, and keeps three extra low-order bits, the last of which is sticky. It then adds or subtracts the significands, renormalizes on the leading one, and truncates the fraction.

The unit works in a flush-to-zero style and produces no special values. An operand whose exponent field is zero counts as zero. A zero result is always the all-zero word. A result too large for the format saturates to the largest finite magnitude and raises an overflow flag. A result too small for a normal encoding becomes zero and raises an underflow flag. A caller presents a word pair with `in_valid` high. The registered outputs then hold that answer until the next valid pair.

Top module: `fp_addsub`

## Requirements
- R1: After reset, out_valid, result, overflow and underflow are all zero until a valid pair has been accepted.
- R2: out_valid is high exactly one cycle after in_valid was high. While in_valid is low, result and both flags keep their previous values.
- R3: op = 0 computes a + b and op = 1 computes a - b. Subtraction inverts the sign bit (bit 31) of b and then follows the addition path.
- R4: For a result whose normalized exponent lies in 1..254, the output carries the sign of the larger-magnitude operand. Its exponent and 23-bit fraction equal the exact sum truncated toward zero, for any exponent difference.
- R5: A result whose exact value is zero is the word 0x00000000, with both flags low, whatever the operand signs.
- R6: An operand with exponent field 0 counts as zero whatever its fraction bits. A sum with one such operand returns the other operand exactly, with b's sign inverted when op = 1.
- R7: When the normalized exponent would exceed 254, overflow is 1 and result is {sign, 0xFE, 0x7FFFFF}.
- R8: When a nonzero result's normalized exponent would be below 1, underflow is 1 and result is 0x00000000.
- R9: overflow and underflow are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept a, b and op this cycle |
| op | input | 1 | 0 = add, 1 = subtract |
| a | input | 32 | First operand, single-precision word |
| b | input | 32 | Second operand, single-precision word |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| result | output | 32 | Sum or difference word |
| overflow | output | 1 | Result saturated at the largest finite magnitude |
| underflow | output | 1 | Nonzero result flushed to zero |

## Verification
Random pairs with unrelated exponents exercise the alignment shifter and the carry-out path of same-sign sums. Pairs that share an exponent and differ in effective sign force deep cancellation, which separates a correct leading-one count from an off-by-one shift. Directed pairs whose exponent gaps are 23 to 31 apart show whether shifted-out bits still reduce a difference by one unit when the result is truncated. A further set near the top and bottom of the exponent range, with denormal-pattern and signed-zero operands, separates the saturating, flushing and clean-zero encodings from ordinary results.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fp_op_e;

  // low-order bits kept below the significand during alignment
  localparam int unsigned GRS_BITS = 3;
endpackage

// File: rtl/fp_align.sv
module fp_align
  import fp_addsub_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned WRK_W  = SIG_W + GRS_BITS
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              op,
  output logic [WRK_W-1:0]  big_sig,
  output logic [WRK_W-1:0]  small_sig,
  output logic [EXP_W-1:0]  big_exp,
  output logic              res_sign,
  output logic              eff_sub
);
  logic               sign_a, sign_b;
  logic               swap;
  logic [EXP_W-1:0]   exp_a, exp_b, exp_small, gap;
  logic [SIG_W-1:0]   sig_a, sig_b, sig_big, sig_small;
  logic [WRK_W-1:0]   ext_small, shifted, lost_mask;
  logic               far_shift, sticky;

  always_comb begin
    sign_a = a[WORD_W-1];
    sign_b = b[WORD_W-1] ^ (op == OP_SUB);   // R3: negate b for subtract
    exp_a  = a[WORD_W-2 -: EXP_W];
    exp_b  = b[WORD_W-2 -: EXP_W];
    // R6: zero exponent field means zero significand (denormals flushed)
    sig_a  = {(exp_a != '0), a[FRAC_W-1:0]} & {SIG_W{(exp_a != '0)}};
    sig_b  = {(exp_b != '0), b[FRAC_W-1:0]} & {SIG_W{(exp_b != '0)}};

    swap      = (b[WORD_W-2:0] > a[WORD_W-2:0]);
    big_exp   = swap ? exp_b : exp_a;
    exp_small = swap ? exp_a : exp_b;
    sig_big   = swap ? sig_b : sig_a;
    sig_small = swap ? sig_a : sig_b;
    res_sign  = swap ? sign_b : sign_a;
    eff_sub   = sign_a ^ sign_b;

    gap       = big_exp - exp_small;
    ext_small = {sig_small, {GRS_BITS{1'b0}}};
    far_shift = (gap >= EXP_W'(WRK_W));
    lost_mask = far_shift ? {WRK_W{1'b1}} : ~({WRK_W{1'b1}} << gap);
    sticky    = |(ext_small & lost_mask);
    shifted   = far_shift ? '0 : (ext_small >> gap);

    big_sig   = {sig_big, {GRS_BITS{1'b0}}};
    small_sig = {shifted[WRK_W-1:1], shifted[0] | sticky};
  end
endmodule

// File: rtl/fp_sig_addsub.sv
module fp_sig_addsub #(
  parameter int unsigned WRK_W = 27,
  localparam int unsigned SUM_W = WRK_W + 1
) (
  input  logic [WRK_W-1:0] big_sig,
  input  logic [WRK_W-1:0] small_sig,
  input  logic             eff_sub,
  output logic [SUM_W-1:0] sum
);
  always_comb begin
    if (eff_sub) sum = {1'b0, big_sig} - {1'b0, small_sig};
    else         sum = {1'b0, big_sig} + {1'b0, small_sig};
  end
endmodule

// File: rtl/fp_norm_pack.sv
module fp_norm_pack #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned SUM_W  = 28,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned LZ_W   = $clog2(SUM_W + 1),
  localparam int unsigned XE_W   = EXP_W + 2,
  localparam int unsigned EMAX   = (1 << EXP_W) - 2
) (
  input  logic [SUM_W-1:0]  sum,
  input  logic [EXP_W-1:0]  big_exp,
  input  logic              res_sign,
  output logic [WORD_W-1:0] word,
  output logic              ovf,
  output logic              unf
);
  logic [LZ_W-1:0]        lz;
  logic [SUM_W-1:0]       norm;
  logic signed [XE_W-1:0] exp_n;
  logic                   is_zero;

  always_comb begin
    lz = LZ_W'(SUM_W);
    for (int i = 0; i < SUM_W; i++) begin
      if (sum[i]) lz = LZ_W'(SUM_W - 1 - i);
    end
    is_zero = (sum == '0);
    norm    = sum << lz;
    exp_n   = $signed({2'b00, big_exp}) + XE_W'(1)
              - $signed({{(XE_W-LZ_W){1'b0}}, lz});
    ovf  = !is_zero && (exp_n > $signed(XE_W'(EMAX)));
    unf  = !is_zero && (exp_n < $signed(XE_W'(1)));
    if (is_zero || unf)  word = '0;                                   // R5, R8
    else if (ovf)        word = {res_sign, EXP_W'(EMAX), {FRAC_W{1'b1}}}; // R7
    else                 word = {res_sign, exp_n[EXP_W-1:0],
                                 norm[SUM_W-2 -: FRAC_W]};            // R4
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fp_addsub_pkg::*;
#(
  parameter int unsigned EXP_W       = 8,
  parameter int unsigned FRAC_W      = 23,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned WRK_W  = FRAC_W + 1 + GRS_BITS,
  localparam int unsigned SUM_W  = WRK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              overflow,
  output logic              underflow
);
  // reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_q_n;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_chain[s] <= 1'b0;
        else        rst_chain[s] <= (s == 0) ? 1'b1 : rst_chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate
  assign rst_q_n = rst_chain[SYNC_STAGES-1];

  logic [WRK_W-1:0]  big_sig, small_sig;
  logic [EXP_W-1:0]  big_exp;
  logic              res_sign, eff_sub;
  logic [SUM_W-1:0]  sum;
  logic [WORD_W-1:0] word_d;
  logic              ovf_d, unf_d;

  fp_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_align (
    .a(a), .b(b), .op(op),
    .big_sig(big_sig), .small_sig(small_sig), .big_exp(big_exp),
    .res_sign(res_sign), .eff_sub(eff_sub)
  );

  fp_sig_addsub #(.WRK_W(WRK_W)) i_sig (
    .big_sig(big_sig), .small_sig(small_sig), .eff_sub(eff_sub), .sum(sum)
  );

  fp_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) i_pack (
    .sum(sum), .big_exp(big_exp), .res_sign(res_sign),
    .word(word_d), .ovf(ovf_d), .unf(unf_d)
  );

  // next-state
  logic [WORD_W-1:0] result_nx;
  logic              ovf_nx, unf_nx, valid_nx;

  always_comb begin
    valid_nx  = in_valid;
    result_nx = result;
    ovf_nx    = overflow;
    unf_nx    = underflow;
    if (in_valid) begin
      result_nx = word_d;
      ovf_nx    = ovf_d;
      unf_nx    = unf_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      out_valid <= valid_nx;
      result    <= result_nx;
      overflow  <= ovf_nx;
      underflow <= unf_nx;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);
  assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(result) && $stable(overflow) && $stable(underflow)));
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(overflow && underflow));
  assert_overflow_saturates_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    overflow |-> (result[WORD_W-2:0] == {EXP_W'((1 << EXP_W) - 2), {FRAC_W{1'b1}}}));
  assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    underflow |-> (result == '0));
  assert_clean_zero_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (result[WORD_W-2 -: EXP_W] == '0) |-> (result == '0));
endmodule

// File: tb/test_fp_addsub.sv
`timescale 1ns/1ps
module test_fp_addsub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, op;
  logic [31:0] a, b;
  logic        out_valid, overflow, underflow;
  logic [31:0] result;

  always #2.5 clk = ~clk;   // 200 MHz

  fp_addsub i_fp_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .overflow(overflow), .underflow(underflow)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic  ev, eo, eu;
  logic [31:0] er;
  string cur_tag = "R1";

  // exact sum truncated toward zero, flush-to-zero rules; returns {ovf, unf, word}
  function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic sub);
    int ex, ey, eb, es, d, p, e;
    logic [23:0] mx, my, mb, ms;
    logic sx, sy, sb;
    logic [127:0] X, Y, R;
    ex = int'(x[30:23]); ey = int'(y[30:23]);
    mx = (ex != 0) ? {1'b1, x[22:0]} : 24'd0;
    my = (ey != 0) ? {1'b1, y[22:0]} : 24'd0;
    sx = x[31]; sy = y[31] ^ sub;
    if (ey > ex || (ey == ex && my > mx)) begin
      eb = ey; mb = my; sb = sy; es = ex; ms = mx;
    end else begin
      eb = ex; mb = mx; sb = sx; es = ey; ms = my;
    end
    d = eb - es;
    X = 128'(mb) << 100;
    if (d > 100) Y = (ms != 0) ? 128'd1 : 128'd0;
    else         Y = (128'(ms) << 100) >> d;
    R = (sx == sy) ? X + Y : X - Y;
    if (R == 0) return 34'd0;
    p = 0;
    for (int i = 0; i < 128; i++) if (R[i]) p = i;
    e = eb + p - 123;
    if (e > 254) return {2'b10, sb, 8'hFE, 23'h7FFFFF};
    if (e < 1)   return {2'b01, 32'd0};
    R = R >> (p - 23);
    return {2'b00, sb, e[7:0], R[22:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // one clock: compare outputs from last cycle, then drive new inputs
  task automatic step(input logic v, input logic o, input logic [31:0] x,
                      input logic [31:0] y, input string tag);
    logic [33:0] m;
    @(negedge clk);
    chk("R2 out_valid", {31'd0, out_valid}, {31'd0, ev});
    chk({cur_tag, " result"}, result, er);
    chk({cur_tag, " flags"}, {30'd0, overflow, underflow}, {30'd0, eo, eu});
    chk("R9 flags exclusive", {31'd0, overflow & underflow}, 32'd0);
    in_valid = v; op = o; a = x; b = y;
    ev = v;
    if (v) begin
      m = model(x, y, o);
      eo = m[33]; eu = m[32]; er = m[31:0];
      cur_tag = tag;
    end else begin
      cur_tag = "R2 hold";
    end
  endtask

  function automatic logic [31:0] rnd_normal(input int emin, input int emax);
    int e;
    e = emin + int'($urandom % 32'(emax - emin + 1));
    return {1'($urandom), e[7:0], 23'($urandom)};
  endfunction

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, y;
    rst_n = 1'b0; in_valid = 1'b0; op = 1'b0; a = '0; b = '0;
    ev = 1'b0; eo = 1'b0; eu = 1'b0; er = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    chk("R1 reset", {result[31:3], out_valid, overflow, underflow}, 32'd0);

    step(0, 0, 32'h3F800000, 32'h3F800000, "R1");
    step(1, 0, 32'h3F800000, 32'h3F800000, "R4 1+1");
    step(1, 1, 32'h40400000, 32'h3F800000, "R3 3-1");
    step(1, 0, 32'h40400000, 32'hBF800000, "R3 3+(-1)");
    step(1, 1, 32'hC0400000, 32'hBF800000, "R3 -3-(-1)");
    step(0, 0, 32'h12345678, 32'h9ABCDEF0, "R2");
    step(0, 1, 32'h7F7FFFFF, 32'h7F7FFFFF, "R2");
    step(1, 1, 32'h3F800000, 32'h3F800000, "R5 1-1");
    step(1, 0, 32'hC1200000, 32'h41200000, "R5 -10+10");
    step(1, 0, 32'h80000000, 32'h80000000, "R5 -0+-0");
    step(1, 0, 32'h00000001, 32'h3F800000, "R6 denormal a");
    step(1, 1, 32'h40A00000, 32'h007FFFFF, "R6 denormal b");
    step(1, 1, 32'h00000000, 32'h40A00000, "R6 zero minus b");
    step(1, 0, 32'h3F800000, 32'h30800000, "R4 far add");
    step(1, 1, 32'h3F800000, 32'h30800000, "R4 far sub");
    step(1, 1, 32'h3F800000, 32'h33C00000, "R4 gap24 sub");
    step(1, 1, 32'h3FC00000, 32'h33800000, "R4 gap24 sub b");
    step(1, 0, 32'h7F7FFFFF, 32'h7F7FFFFF, "R7 overflow pos");
    step(1, 1, 32'hFF000000, 32'h7F000000, "R7 overflow neg");
    step(1, 1, 32'h00800001, 32'h00800000, "R8 underflow");
    step(1, 0, 32'h80C00000, 32'h00800000, "R8 underflow mixed");
    step(1, 1, 32'h00800000, 32'h80800000, "R4 min normal doubled");
    // exponent gaps around the extra-bit width
    for (int g = 20; g < 32; g++) begin
      x = {1'b0, 8'd150, 23'($urandom)};
      y = {1'b0, 8'(150 - g), 23'($urandom)};
      step(1, 1, x, y, "R4 gap sweep sub");
      step(1, 0, x, y, "R4 gap sweep add");
    end
    // random, wide exponent range
    for (int k = 0; k < 1500; k++) begin
      x = rnd_normal(1, 254);
      y = rnd_normal(1, 254);
      step(($urandom % 8) != 0, 1'($urandom), x, y, "R4 random");
    end
    // cancellation: equal or adjacent exponents
    for (int k = 0; k < 1500; k++) begin
      x = rnd_normal(60, 200);
      y = {~x[31], 8'(int'(x[30:23]) - int'($urandom % 2)), 23'($urandom)};
      if (($urandom % 4) == 0) y[22:0] = x[22:0] ^ 23'(1 << ($urandom % 23));
      step(1, 0, x, y, "R4 cancel");
    end
    // edges of the exponent range
    for (int k = 0; k < 600; k++) begin
      if (k % 2 == 0) begin
        x = rnd_normal(250, 254); y = rnd_normal(250, 254);
      end else begin
        x = rnd_normal(1, 4); y = rnd_normal(1, 4);
      end
      step(1, 1'($urandom), x, y, "R7 R8 edge");
    end
    step(0, 0, 32'h0, 32'h0, "R2");
    step(0, 0, 32'h0, 32'h0, "R2");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule